// File: doc/BRIEF.md
# Auxiliary Output Divider and Selector

This block takes a fast oscillator clock and produces one registered output pin. The pin can carry a divided copy of the oscillator, or one of several internal status and timing points. The divider counts a programmable integer A. It offers two shapes: a narrow pulse that is high for one oscillator period in every A periods, and a 50% square wave at the oscillator rate divided by 2A. The square wave comes from toggling on each divider terminal count.

The configuration is static. A 5-bit divide value, a toggle-stage enable and a 3-bit source select arrive as ports. A 3-bit source select chooses what reaches the pin:

- the pulse path or the square-wave path;
- the reference divider pulse or the feedback divider pulse;
- the lock flag;
- a constant level.

A divide value of 0 or 1 is illegal and parks the divider, so both divided paths stay low. A new divide value is picked up only when the current count ends. This keeps the output free of shortened pulses.

Top module: `auxdiv_top`

## Requirements
- R1: With a legal divide value A (2 to 31) and select 110, the output repeats with a period of exactly A clock cycles.
- R2: With select 110, the output is high for exactly one clock cycle in each period, giving a duty of 1/A.
- R3: With select 101 and the toggle enable high, the output is high for A cycles and low for A cycles, a period of 2A.
- R4: With select 101 and the toggle enable low, the output stays low.
- R5: A divide value of 0 or 1 parks the divider, and the output stays low on selects 101 and 110.
- R6: Select encoding is 000 low, 001 lock flag, 010 feedback divider pulse, 011 high, 100 reference divider pulse, 111 low. The output shows the selected point one clock after it is sampled.
- R7: A change of the divide value during a count takes effect only after the current period finishes. That period keeps its old length and the next one uses the new value.
- R8: A synchronous reset drives the output low on the next clock and restarts the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| divVal | input | 5 | Divide value A (legal 2 to 31) |
| halfEn | input | 1 | Enables the square-wave toggle stage |
| srcSel | input | 3 | Output source select |
| refPulse | input | 1 | Reference divider output pulse |
| fbPulse | input | 1 | Feedback divider output pulse |
| lockDet | input | 1 | Digital lock flag |
| auxOut | output | 1 | Registered output pin |

## Verification
A count that reloads with an off-by-one value shows up at the pin as a period of A±1 from the first full period after reset. For this reason every legal A is measured in both shapes, comparing high time and low time separately. A stuck or mis-gated toggle stage shows within 2A cycles as a wrong high time or a flat output. A reload that samples the divide value too early shows as a shortened period directly after a mid-count change. A mux decode slip shows one cycle after the select is applied.

// File: rtl/auxdiv_pkg.sv
package auxdiv_pkg;

  typedef enum logic [2:0] {
    SEL_LOW_A = 3'b000,
    SEL_LOCK  = 3'b001,
    SEL_FB    = 3'b010,
    SEL_HIGH  = 3'b011,
    SEL_REF   = 3'b100,
    SEL_HALF  = 3'b101,
    SEL_PULSE = 3'b110,
    SEL_LOW_B = 3'b111
  } src_sel_e;

  // Strobes from the count control into the output datapath
  typedef struct packed {
    logic tick;   // terminal count of an armed period
    logic idle;   // divider parked (illegal divide value)
  } div_strobe_t;

endpackage

// File: rtl/auxdiv_ctrl.sv
module auxdiv_ctrl
  import auxdiv_pkg::*;
#(
  parameter int DIV_W   = 5,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divVal,
  output div_strobe_t      strb
);

  localparam logic [DIV_W-1:0] MinVal = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] cnt;
  logic             armed;
  logic             atZero;

  assign atZero = (cnt == '0);

  // The divide value is sampled only at a zero count, so a change
  // waits for the running period to finish.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (atZero) begin
      if (divVal >= MinVal) begin
        cnt   <= divVal - 1'b1;
        armed <= 1'b1;
      end else begin
        armed <= 1'b0;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    strb.tick = armed && atZero;
    strb.idle = !armed;
  end

endmodule

// File: rtl/auxdiv_dpath.sv
module auxdiv_dpath
  import auxdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  div_strobe_t strb,
  input  logic        halfEn,
  input  logic [2:0]  srcSel,
  input  logic        refPulse,
  input  logic        fbPulse,
  input  logic        lockDet,
  output logic        auxOut
);

  logic pulseQ;
  logic togQ;
  logic muxD;
  logic outQ;

  always_ff @(posedge clk) begin
    if (rst) pulseQ <= 1'b0;
    else     pulseQ <= strb.tick;
  end

  always_ff @(posedge clk) begin
    if (rst || !halfEn || strb.idle) togQ <= 1'b0;
    else if (strb.tick)              togQ <= ~togQ;
  end

  always_comb begin
    unique case (src_sel_e'(srcSel))
      SEL_LOCK:  muxD = lockDet;
      SEL_FB:    muxD = fbPulse;
      SEL_HIGH:  muxD = 1'b1;
      SEL_REF:   muxD = refPulse;
      SEL_HALF:  muxD = togQ;
      SEL_PULSE: muxD = pulseQ;
      default:   muxD = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outQ <= 1'b0;
    else     outQ <= muxD;
  end

  assign auxOut = outQ;

endmodule

// File: rtl/auxdiv_top.sv
module auxdiv_top
  import auxdiv_pkg::*;
#(
  parameter int DIV_W   = 5,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divVal,
  input  logic             halfEn,
  input  logic [2:0]       srcSel,
  input  logic             refPulse,
  input  logic             fbPulse,
  input  logic             lockDet,
  output logic             auxOut
);

  div_strobe_t strb;

  auxdiv_ctrl #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .divVal (divVal),
    .strb   (strb)
  );

  auxdiv_dpath u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .halfEn   (halfEn),
    .srcSel   (srcSel),
    .refPulse (refPulse),
    .fbPulse  (fbPulse),
    .lockDet  (lockDet),
    .auxOut   (auxOut)
  );

endmodule

// File: rtl/auxdiv_chk.sv
module auxdiv_chk
  import auxdiv_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] divVal,
  input logic             halfEn,
  input logic [2:0]       srcSel,
  input logic             refPulse,
  input logic             fbPulse,
  input logic             lockDet,
  input logic             auxOut,
  input div_strobe_t      strb
);

  // R1: terminal counts of an armed divider are at least two cycles apart
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    strb.tick |=> !strb.tick);

  // R2: a pulse-mode high lasts a single cycle
  a_r2_single_high: assert property (@(posedge clk) disable iff (rst)
    (srcSel == 3'b110 && $past(srcSel) == 3'b110 && auxOut) |=> !auxOut);

  // R4: gated toggle stage keeps the pin low
  a_r4_half_gated: assert property (@(posedge clk) disable iff (rst)
    (!halfEn && srcSel == 3'b101) |=> !auxOut);

  // R5: a parked divider produces no terminal count
  a_r5_parked_quiet: assert property (@(posedge clk) disable iff (rst)
    strb.idle |-> !strb.tick);

  // R6: constant and pass-through selects
  a_r6_const_high: assert property (@(posedge clk) disable iff (rst)
    (srcSel == 3'b011) |=> auxOut);
  a_r6_const_low: assert property (@(posedge clk) disable iff (rst)
    (srcSel == 3'b000 || srcSel == 3'b111) |=> !auxOut);
  a_r6_ref_pass: assert property (@(posedge clk) disable iff (rst)
    (srcSel == 3'b100) |=> (auxOut == $past(refPulse)));

  // R8: reset clears the pin on the next clock
  a_r8_reset_low: assert property (@(posedge clk)
    rst |=> !auxOut);

endmodule

bind auxdiv_top auxdiv_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .divVal   (divVal),
  .halfEn   (halfEn),
  .srcSel   (srcSel),
  .refPulse (refPulse),
  .fbPulse  (fbPulse),
  .lockDet  (lockDet),
  .auxOut   (auxOut),
  .strb     (strb)
);

// File: tb/auxdiv_top_bench.sv
module auxdiv_top_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] divVal = 5'd0;
  logic       halfEn = 1'b0;
  logic [2:0] srcSel = 3'b000;
  logic       refPulse = 1'b0;
  logic       fbPulse = 1'b0;
  logic       lockDet = 1'b0;
  logic       auxOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  auxdiv_top u_auxdiv_top (
    .clk(clk), .rst(rst), .divVal(divVal), .halfEn(halfEn), .srcSel(srcSel),
    .refPulse(refPulse), .fbPulse(fbPulse), .lockDet(lockDet), .auxOut(auxOut)
  );

  // Mux vectors: {sel[2:0], lock, ref, fb, expected}; divider parked (A = 0)
  localparam logic [6:0] MuxVec [12] = '{
    7'b000_111_0, 7'b001_100_1, 7'b001_011_0, 7'b010_001_1,
    7'b010_110_0, 7'b011_000_1, 7'b100_010_1, 7'b100_101_0,
    7'b111_111_0, 7'b101_111_0, 7'b110_111_0, 7'b011_111_1
  };

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // Waits for a rising edge of the pin, then counts high and low cycles
  task automatic measure(output int hi, output int lo);
    int guard = 0;
    while (auxOut !== 1'b0 && guard < 300) begin @(negedge clk); guard++; end
    while (auxOut !== 1'b1 && guard < 300) begin @(negedge clk); guard++; end
    hi = 0; lo = 0;
    while (auxOut === 1'b1 && hi < 300) begin hi++; @(negedge clk); end
    while (auxOut === 1'b0 && lo < 300) begin lo++; @(negedge clk); end
  endtask

  // From a rise in pulse mode, counts cycles to the next rise
  task automatic gap(output int n);
    n = 1;
    @(negedge clk);
    while (auxOut !== 1'b1 && n < 300) begin n++; @(negedge clk); end
  endtask

  initial begin
    int hi, lo, n;
    doReset();

    // R8: reset state
    check(int'(auxOut), 0, "R8 reset state");

    // R6 / R5: mux table with the divider parked
    foreach (MuxVec[i]) begin
      @(negedge clk);
      srcSel = MuxVec[i][6:4]; lockDet = MuxVec[i][3];
      refPulse = MuxVec[i][2]; fbPulse = MuxVec[i][1]; halfEn = 1'b1;
      @(negedge clk);
      check(int'(auxOut), int'(MuxVec[i][0]),
            (MuxVec[i][6:4] inside {3'b101, 3'b110}) ? "R5 parked divider" : "R6 select");
    end
    lockDet = 0; refPulse = 0; fbPulse = 0;

    // R1 R2: pulse mode over every legal A
    for (int a = 2; a <= 31; a++) begin
      divVal = 5'(a); srcSel = 3'b110; halfEn = 1'b0;
      doReset();
      measure(hi, lo);
      check(hi, 1, $sformatf("R2 high time A=%0d", a));
      check(hi + lo, a, $sformatf("R1 period A=%0d", a));
    end

    // R3: square wave over every legal A
    for (int a = 2; a <= 31; a++) begin
      divVal = 5'(a); srcSel = 3'b101; halfEn = 1'b1;
      doReset();
      measure(hi, lo);
      check(hi, a, $sformatf("R3 high time A=%0d", a));
      check(lo, a, $sformatf("R3 low time A=%0d", a));
    end

    // R4: toggle stage disabled
    divVal = 5'd4; srcSel = 3'b101; halfEn = 1'b0;
    doReset();
    n = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); n += int'(auxOut); end
    check(n, 0, "R4 toggle disabled high cycles");

    // R5: divide value of 1 in pulse mode
    divVal = 5'd1; srcSel = 3'b110;
    doReset();
    n = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); n += int'(auxOut); end
    check(n, 0, "R5 A=1 high cycles");

    // R7: change mid-count
    divVal = 5'd10; srcSel = 3'b110;
    doReset();
    measure(hi, lo);          // returns at a rise
    divVal = 5'd3;
    gap(n);
    check(n, 10, "R7 period after change keeps old A");
    gap(n);
    check(n, 3, "R7 next period uses new A");

    // R8: reset mid-operation forces the pin low
    srcSel = 3'b011;
    @(negedge clk); @(negedge clk);
    check(int'(auxOut), 1, "R6 high before reset");
    rst = 1'b1;
    @(negedge clk);
    check(int'(auxOut), 0, "R8 low after reset");
    rst = 1'b0;
    @(negedge clk);
    check(int'(auxOut), 1, "R8 recovers after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule